// File: doc/BRIEF.md
# Camera Register Bank with Lookup Table Loader

This block is the 16-bit control register bank of an image sensor controller. Software fills a 512-entry lookup table by writing one data address again and again. A write pointer inside the block steps forward on each write, so no index register is needed. The pixel path reads the table through a separate indexed port.

A brightness engine outside the block reports a gamma code and an image average. The bank holds both values in a read-only status register. The gamma code reaches the pixel path only after two frame-start strobes, through a two-stage delay.

A combined version/reset address returns fixed revision fields when read. Writing a 1 to bit 0 of that address starts a one-cycle internal soft reset. The soft reset clears the pointer, the status and the gamma delay, and leaves the table contents untouched.

Top module: `cam_reg_bank`

## Requirements
- R1: After reset, reading address 0xD returns 0 and `gamma_apply_o` is 0.
- R2: The first table write (address 0xC) after any reset lands at index 0. Each later write lands at the next index.
- R3: Only data bits [11:0] are stored in the table. Bits [15:12] of the write data are discarded.
- R4: After 512 table writes the pointer stays at its end. Further table writes are dropped and leave all entries unchanged until the next reset.
- R5: Reading address 0xF returns the version word: PCB revision in [15:12], hardware version in [11:8], RTL major in [7:4], RTL minor in [3:0]. With the defaults the word is 0x2137.
- R6: Reading address 0xD returns the last captured gamma code in [12:8], the image average in [7:0], and zeros in [15:13]. The capture is visible one cycle after `stat_valid_i`.
- R7: A captured gamma code appears on `gamma_apply_o` after the second `frame_start_i` strobe that follows the capture. A capture in the same cycle as a strobe counts only from the next strobe. `gamma_apply_o` changes only on a strobe or a soft reset.
- R8: A write to 0xF with bit 0 set produces a one-cycle internal pulse. On the following clock edge that pulse clears the write pointer, the status fields and both gamma stages, and it keeps the table contents. A write to 0xF with bit 0 clear has no effect.
- R9: Writes to 0xD and to undefined addresses change no state. Reads of 0xC and of undefined addresses return 0.
- R10: `lut_rd_data_o` returns the entry at `lut_rd_idx_i` one clock after the index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data (combinational from addr_i) |
| stat_valid_i | input | 1 | Brightness engine result valid |
| stat_gamma_i | input | 5 | Computed gamma code |
| stat_avg_i | input | 8 | Computed image average |
| frame_start_i | input | 1 | Frame boundary strobe |
| gamma_apply_o | output | 5 | Gamma code applied to the pixel path |
| lut_rd_idx_i | input | 9 | Table read index |
| lut_rd_data_o | output | 12 | Table read data, one-cycle latency |

## Verification
A new brightness result and a frame-start strobe can land in the same cycle. Then the first delay stage must take the code held before the capture, and the new code must wait two more strobes. The bench raises `stat_valid_i` and `frame_start_i` on one edge. It then checks that the status register shows the new code at once, that the applied code stays at its old value through the next strobe, and that the new code shows up only on the strobe after that.

// File: rtl/cam_reg_pkg.sv
package cam_reg_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 4;
  localparam int GAMMA_W = 5;
  localparam int AVG_W   = 8;

  localparam logic [ADDR_W-1:0] ADDR_LUT  = 4'hC;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 4'hD;
  localparam logic [ADDR_W-1:0] ADDR_VER  = 4'hF;

  typedef struct packed {
    logic [GAMMA_W-1:0] gamma;
    logic [AVG_W-1:0]   avg;
  } stat_t;
endpackage

// File: rtl/cam_lut_store.sv
module cam_lut_store #(
  parameter int DEPTH = 512,
  parameter int DW    = 12,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(DEPTH);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic             wr_ok;

  assign wr_ok = wr_i && (ptr_q != PTR_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (clr_i)  ptr_q <= '0;
    else if (wr_ok)  ptr_q <= ptr_q + 1'b1;
  end

  // table contents survive every reset
  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[ptr_q[IDX_W-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= mem_q[rd_idx_i];
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/cam_stat_capture.sv
module cam_stat_capture
  import cam_reg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               valid_i,
  input  logic [GAMMA_W-1:0] gamma_i,
  input  logic [AVG_W-1:0]   avg_i,
  output stat_t              stat_o
);
  stat_t stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       stat_q <= '0;
    else if (clr_i)    stat_q <= '0;
    else if (valid_i)  stat_q <= '{gamma: gamma_i, avg: avg_i};
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/cam_gamma_delay.sv
module cam_gamma_delay #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         strobe_i,
  input  logic [W-1:0] gamma_i,
  output logic [W-1:0] head_o,
  output logic [W-1:0] gamma_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       stg_q <= '0;
        else if (clr_i)    stg_q <= '0;
        else if (strobe_i) stg_q <= gamma_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       stg_q <= '0;
        else if (clr_i)    stg_q <= '0;
        else if (strobe_i) stg_q <= {stg_q[STAGES-2:0], gamma_i};
      end
    end
  endgenerate

  assign head_o  = stg_q[0];
  assign gamma_o = stg_q[STAGES-1];
endmodule

// File: rtl/cam_reg_bank.sv
module cam_reg_bank
  import cam_reg_pkg::*;
#(
  parameter int          LUT_DEPTH    = 512,
  parameter int          LUT_W        = 12,
  parameter int          GAMMA_STAGES = 2,
  parameter logic [3:0]  PCB_REV      = 4'h2,
  parameter logic [3:0]  HW_REV       = 4'h1,
  parameter logic [3:0]  RTL_MAJ      = 4'h3,
  parameter logic [3:0]  RTL_MIN      = 4'h7,
  localparam int LUT_IDX_W = $clog2(LUT_DEPTH),
  localparam int LUT_PTR_W = $clog2(LUT_DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic                 stat_valid_i,
  input  logic [GAMMA_W-1:0]   stat_gamma_i,
  input  logic [AVG_W-1:0]     stat_avg_i,
  input  logic                 frame_start_i,
  output logic [GAMMA_W-1:0]   gamma_apply_o,
  input  logic [LUT_IDX_W-1:0] lut_rd_idx_i,
  output logic [LUT_W-1:0]     lut_rd_data_o
);
  localparam logic [DATA_W-1:0] VER_WORD = {PCB_REV, HW_REV, RTL_MAJ, RTL_MIN};

  logic                 srst_q;
  logic                 srst_d;
  logic                 lut_wr;
  logic [LUT_PTR_W-1:0] lut_ptr;
  logic [GAMMA_W-1:0]   gamma_head;
  stat_t                stat;
  logic                 unused_hi;

  assign srst_d = wr_en_i && (addr_i == ADDR_VER) && wdata_i[0];
  // table writes in the pulse cycle are dropped: clear wins
  assign lut_wr = wr_en_i && (addr_i == ADDR_LUT) && !srst_q;
  assign unused_hi = ^wdata_i[DATA_W-1:LUT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) srst_q <= 1'b0;
    else         srst_q <= srst_d;
  end

  cam_lut_store #(.DEPTH(LUT_DEPTH), .DW(LUT_W)) u_lut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (srst_q),
    .wr_i      (lut_wr),
    .wdata_i   (wdata_i[LUT_W-1:0]),
    .rd_idx_i  (lut_rd_idx_i),
    .rd_data_o (lut_rd_data_o),
    .ptr_o     (lut_ptr)
  );

  cam_stat_capture u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (srst_q),
    .valid_i (stat_valid_i),
    .gamma_i (stat_gamma_i),
    .avg_i   (stat_avg_i),
    .stat_o  (stat)
  );

  cam_gamma_delay #(.W(GAMMA_W), .STAGES(GAMMA_STAGES)) u_gdly (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (srst_q),
    .strobe_i (frame_start_i),
    .gamma_i  (stat.gamma),
    .head_o   (gamma_head),
    .gamma_o  (gamma_apply_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_STAT: rdata_o[GAMMA_W+AVG_W-1:0] = stat;
      ADDR_VER:  rdata_o = VER_WORD;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cam_reg_bank_chk.sv
module cam_reg_bank_chk
  import cam_reg_pkg::*;
#(
  parameter int LUT_DEPTH = 512,
  localparam int LUT_PTR_W = $clog2(LUT_DEPTH + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [DATA_W-1:0]    wdata_i,
  input logic [DATA_W-1:0]    rdata_o,
  input logic                 frame_start_i,
  input logic [GAMMA_W-1:0]   gamma_apply_o,
  input logic [LUT_PTR_W-1:0] lut_ptr,
  input logic                 srst_q,
  input logic [GAMMA_W-1:0]   gamma_head
);
  localparam logic [LUT_PTR_W-1:0] PTR_END = LUT_PTR_W'(LUT_DEPTH);

  logic lut_req;
  logic ver_hit;
  assign lut_req = wr_en_i && (addr_i == ADDR_LUT);
  assign ver_hit = wr_en_i && (addr_i == ADDR_VER) && wdata_i[0];

  assert_ptr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lut_req && !srst_q && lut_ptr != PTR_END) |=> lut_ptr == $past(lut_ptr) + 1'b1);

  assert_ptr_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lut_ptr <= PTR_END);

  assert_ptr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lut_ptr == PTR_END && !srst_q) |=> lut_ptr == PTR_END);

  assert_stat_top_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_STAT) |-> rdata_o[DATA_W-1:GAMMA_W+AVG_W] == '0);

  assert_gamma_steady_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_start_i && !srst_q) |=> $stable(gamma_apply_o));

  assert_gamma_shift_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && !srst_q) |=> gamma_apply_o == $past(gamma_head));

  assert_soft_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ver_hit |=> srst_q);

  assert_soft_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> (lut_ptr == '0 && gamma_apply_o == '0 && gamma_head == '0));

  assert_undef_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != ADDR_STAT && addr_i != ADDR_VER) |-> rdata_o == '0);
endmodule

bind cam_reg_bank cam_reg_bank_chk #(.LUT_DEPTH(LUT_DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .frame_start_i (frame_start_i),
  .gamma_apply_o (gamma_apply_o),
  .lut_ptr       (lut_ptr),
  .srst_q        (srst_q),
  .gamma_head    (gamma_head)
);

// File: tb/cam_reg_bank_test.sv
module cam_reg_bank_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        stat_valid_i = 1'b0;
  logic [4:0]  stat_gamma_i = '0;
  logic [7:0]  stat_avg_i = '0;
  logic        frame_start_i = 1'b0;
  logic [4:0]  gamma_apply_o;
  logic [8:0]  lut_rd_idx_i = '0;
  logic [11:0] lut_rd_data_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  cam_reg_bank uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .stat_valid_i(stat_valid_i),
    .stat_gamma_i(stat_gamma_i), .stat_avg_i(stat_avg_i),
    .frame_start_i(frame_start_i), .gamma_apply_o(gamma_apply_o),
    .lut_rd_idx_i(lut_rd_idx_i), .lut_rd_data_o(lut_rd_data_o)
  );

  // {write data, expected stored entry}
  localparam logic [27:0] VEC [8] = '{
    {16'h0123, 12'h123}, {16'hF456, 12'h456}, {16'h8FFF, 12'hFFF}, {16'h0000, 12'h000},
    {16'h7A5A, 12'hA5A}, {16'h1001, 12'h001}, {16'hC800, 12'h800}, {16'h3ABC, 12'hABC}
  };

  function automatic logic [11:0] fill_val(int i);
    return 12'(i * 37);
  endfunction

  function automatic logic [11:0] exp_entry(int i);
    return (i < 8) ? VEC[i][11:0] : fill_val(i);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic reg_rd(logic [3:0] a, output logic [15:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic lut_rd(int i, output logic [11:0] d);
    @(negedge clk_i);
    lut_rd_idx_i = 9'(i);
    @(negedge clk_i);
    d = lut_rd_data_o;
  endtask

  task automatic push_stat(logic [4:0] g, logic [7:0] a, bit with_strobe);
    @(negedge clk_i);
    stat_valid_i = 1'b1; stat_gamma_i = g; stat_avg_i = a; frame_start_i = with_strobe;
    @(negedge clk_i);
    stat_valid_i = 1'b0; frame_start_i = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk_i);
    frame_start_i = 1'b1;
    @(negedge clk_i);
    frame_start_i = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic [11:0] ld;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state, R5 version word
    reg_rd(4'hD, rd); check("R1 status", rd, 16'h0000);
    check("R1 gamma_apply", gamma_apply_o, 5'h0);
    reg_rd(4'hF, rd); check("R5 version", rd, 16'h2137);

    // R2 R3 vector table walk: first writes land at 0,1,...
    for (int i = 0; i < 8; i++) reg_wr(4'hC, VEC[i][27:12]);
    for (int i = 0; i < 8; i++) begin
      lut_rd(i, ld);
      check("R2/R3 entry", ld, VEC[i][11:0]);
    end

    // fill to the end, then overflow writes must be dropped (R4)
    for (int i = 8; i < 512; i++) reg_wr(4'hC, {4'hE, fill_val(i)});
    reg_wr(4'hC, 16'h0777);
    reg_wr(4'hC, 16'h0777);
    for (int i = 0; i < 512; i++) begin
      lut_rd(i, ld);
      check("R4 entry after overflow", ld, exp_entry(i));
    end

    // R10 one-cycle latency: data appears one edge after index change
    @(negedge clk_i); lut_rd_idx_i = 9'd2;
    @(negedge clk_i); lut_rd_idx_i = 9'd4;
    check("R10 latency idx2", lut_rd_data_o, 12'hFFF);
    @(negedge clk_i);
    check("R10 latency idx4", lut_rd_data_o, 12'hA5A);

    // R6 status capture, R7 two-strobe gamma delay
    push_stat(5'h09, 8'h44, 1'b0);
    reg_rd(4'hD, rd); check("R6 status", rd, 16'h0944);
    check("R7 no strobe yet", gamma_apply_o, 5'h00);
    strobe();
    check("R7 after one strobe", gamma_apply_o, 5'h00);
    strobe();
    check("R7 after two strobes", gamma_apply_o, 5'h09);

    // R7 capture coincident with a strobe
    push_stat(5'h15, 8'h80, 1'b1);
    reg_rd(4'hD, rd); check("R6 coincident status", rd, 16'h1580);
    check("R7 coincident hold", gamma_apply_o, 5'h09);
    strobe();
    check("R7 coincident +1", gamma_apply_o, 5'h09);
    strobe();
    check("R7 coincident +2", gamma_apply_o, 5'h15);

    // R9 write to read-only status is ignored; undefined reads are zero
    reg_wr(4'hD, 16'hFFFF);
    reg_rd(4'hD, rd); check("R9 ro write", rd, 16'h1580);
    reg_rd(4'hC, rd); check("R9 read lut addr", rd, 16'h0000);
    reg_rd(4'h3, rd); check("R9 read undef", rd, 16'h0000);

    // R8 bit0 clear: no reset
    reg_wr(4'hF, 16'hFFFE);
    @(negedge clk_i);
    reg_rd(4'hD, rd); check("R8 no-reset status", rd, 16'h1580);
    check("R8 no-reset gamma", gamma_apply_o, 5'h15);

    // R8 soft reset
    reg_wr(4'hF, 16'h0001);
    @(negedge clk_i);
    reg_rd(4'hD, rd); check("R8 status cleared", rd, 16'h0000);
    check("R8 gamma cleared", gamma_apply_o, 5'h00);
    lut_rd(5, ld); check("R8 table kept", ld, 12'h001);

    // R9 writes elsewhere do not move the pointer; R2 restart at 0
    reg_wr(4'h3, 16'h0111);
    reg_wr(4'hD, 16'h0222);
    reg_wr(4'hC, 16'h5ABC);
    lut_rd(0, ld); check("R2 pointer restart", ld, 12'hABC);
    lut_rd(1, ld); check("R9 pointer untouched", ld, 12'h456);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule